// File: doc/BRIEF.md
# Masked Vector Compare and Arithmetic Lane

This block is one execution lane of a vector unit. It holds a small file of vector registers, each with 64 signed 64-bit elements, plus a 64-bit element mask and a length register that sets how many leading elements an operation touches. A compare runs over the active elements and records one boolean per element in the mask. The compare can pit two vector registers against each other or a vector register against a scalar. Later add and subtract operations use that mask to decide which elements they may overwrite. A population-count command copies the number of set mask bits out as a scalar.

Commands arrive on one command port with an opcode and operand fields. Single-cycle commands take effect at the edge that accepts them. These are setting the length, writing one element, clearing the mask and counting mask bits. Compare and arithmetic commands walk the elements one per clock. They hold `busy` high while they run and then raise `done` for a single cycle. Any command offered while `busy` is high is dropped. A combinational read port returns any element, so software-side state and results can be seen without extra commands.

Top module: `vlane_top`

## Requirements
- R1: After reset, `busy` and `done` are low, `vlen` is 64, `maskBits` is all ones, `maskOn` is low, `popCount` is 0 and every element reads 0.
- R2: Opcode 1 loads the length register from `cmdScalar`, saturating at 64, in the accepting cycle; the value 0 is kept as 0.
- R3: Opcode 2 writes `cmdScalar` into element `cmdIdx` of register `cmdDst`; `rdData` shows element `rdIdx` of register `rdReg` without a clock delay.
- R4: Opcode 3 (compare `cmdSrcA` against `cmdSrcB`, both vectors) sets mask bit i exactly when the signed predicate holds for element i. The predicate is taken from `cmdPred`: 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal, 5 less-or-equal. Masking is switched on by the compare.
- R5: Opcode 4 is the same compare with `cmdScalar` taking the place of every element of the second operand.
- R6: Elements whose index is at or above the length register are never compared or written; a compare leaves their mask bits at 0.
- R7: Opcodes 5 (vector add), 6 (vector subtract), 7 (add scalar) and 8 (subtract scalar) write `cmdDst` = `cmdSrcA` op operand. While `maskOn` is high, only elements whose mask bit is 1 are written.
- R8: Opcode 10 sets all 64 mask bits to 1 and lowers `maskOn` in the accepting cycle; arithmetic after it writes every active element.
- R9: Opcode 9 loads `popCount` with the number of 1 bits in the mask, visible in the cycle after acceptance.
- R10: A compare or arithmetic command holds `busy` high for max(length, 1) cycles after the accepting edge; `done` is high for exactly the one following cycle.
- R11: A command presented while `busy` is high has no effect on any register, element, mask or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 4 | Opcode |
| cmdPred | input | 3 | Compare predicate code |
| cmdDst | input | 2 | Destination vector register |
| cmdSrcA | input | 2 | First source vector register |
| cmdSrcB | input | 2 | Second source vector register |
| cmdIdx | input | 6 | Element index for single-element write |
| cmdScalar | input | 64 | Scalar operand, length value or element data |
| busy | output | 1 | Element walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rdReg | input | 2 | Read port register select |
| rdIdx | input | 6 | Read port element select |
| rdData | output | 64 | Selected element |
| maskBits | output | 64 | Element mask |
| maskOn | output | 1 | Masking active |
| popCount | output | 7 | Last population count |
| vlen | output | 7 | Active vector length |

## Verification
Single-cycle commands change their state at the edge that accepts them. The bench therefore reads `vlen`, `maskBits`, `maskOn` and `popCount` at the falling edge right after acceptance. For an element walk, the bench counts falling edges with `busy` high from that same point and expects max(length, 1) of them. `done` is expected at the first falling edge where `busy` has dropped, and the mask and destination elements are compared against the bench's own model only after that. Element reads go through the combinational port, sampled one time step after the index is driven at a falling edge.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  localparam int ELEM_W   = 64;
  localparam int MAX_VL   = 64;
  localparam int NUM_VREG = 4;
  localparam int IDX_W    = $clog2(MAX_VL);
  localparam int REG_W    = $clog2(NUM_VREG);
  localparam int VL_W     = IDX_W + 1;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_SETVL   = 4'd1,
    OP_WRELEM  = 4'd2,
    OP_CMPVV   = 4'd3,
    OP_CMPVS   = 4'd4,
    OP_ADDVV   = 4'd5,
    OP_SUBVV   = 4'd6,
    OP_ADDVS   = 4'd7,
    OP_SUBVS   = 4'd8,
    OP_POPCNT  = 4'd9,
    OP_CLRMASK = 4'd10
  } opcode_e;

  typedef enum logic [2:0] {
    PR_EQ = 3'd0,
    PR_NE = 3'd1,
    PR_GT = 3'd2,
    PR_LT = 3'd3,
    PR_GE = 3'd4,
    PR_LE = 3'd5
  } pred_e;

  typedef struct packed {
    logic              setVl;
    logic              wrElem;
    logic              clrMask;
    logic              popCnt;
    logic              cmpStart;
    logic              stepCmp;
    logic              stepArith;
    logic              useScalar;
    logic              doSub;
    pred_e             pred;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  wrIdx;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  srcA;
    logic [REG_W-1:0]  srcB;
    logic [ELEM_W-1:0] scalar;
  } strobe_t;
endpackage

// File: rtl/vlane_ctrl.sv
module vlane_ctrl
  import vlane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [2:0]        cmdPred,
  input  logic [REG_W-1:0]  cmdDst,
  input  logic [REG_W-1:0]  cmdSrcA,
  input  logic [REG_W-1:0]  cmdSrcB,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ELEM_W-1:0] cmdScalar,
  input  logic [VL_W-1:0]   vl,
  output strobe_t           stb,
  output logic              busy,
  output logic              done
);
  opcode_e opc;
  logic accept, isCmpCmd, isVecCmd, lastStep, live;
  logic [IDX_W-1:0]  elemIdx;
  logic              cmpQ, scalarSelQ, subQ;
  logic [2:0]        predQ;
  logic [REG_W-1:0]  dstQ, srcAQ, srcBQ;
  logic [ELEM_W-1:0] scalarQ;
  logic [VL_W-1:0]   idxWide;

  always_comb begin
    opc      = opcode_e'(cmdOp);
    accept   = cmdValid && !busy;
    isCmpCmd = (opc == OP_CMPVV) || (opc == OP_CMPVS);
    isVecCmd = isCmpCmd || (opc == OP_ADDVV) || (opc == OP_SUBVV) ||
               (opc == OP_ADDVS) || (opc == OP_SUBVS);
    idxWide  = {1'b0, elemIdx};
    lastStep = (idxWide + VL_W'(1)) >= vl;
    live     = busy && (idxWide < vl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      elemIdx    <= '0;
      cmpQ       <= 1'b0;
      scalarSelQ <= 1'b0;
      subQ       <= 1'b0;
      predQ      <= '0;
      dstQ       <= '0;
      srcAQ      <= '0;
      srcBQ      <= '0;
      scalarQ    <= '0;
    end else begin
      done <= busy && lastStep;
      if (accept && isVecCmd) begin
        busy       <= 1'b1;
        elemIdx    <= '0;
        cmpQ       <= isCmpCmd;
        scalarSelQ <= (opc == OP_CMPVS) || (opc == OP_ADDVS) || (opc == OP_SUBVS);
        subQ       <= (opc == OP_SUBVV) || (opc == OP_SUBVS);
        predQ      <= cmdPred;
        dstQ       <= cmdDst;
        srcAQ      <= cmdSrcA;
        srcBQ      <= cmdSrcB;
        scalarQ    <= cmdScalar;
      end else if (busy) begin
        if (lastStep) busy <= 1'b0;
        else          elemIdx <= elemIdx + 1'b1;
      end
    end
  end

  always_comb begin
    stb.setVl     = accept && (opc == OP_SETVL);
    stb.wrElem    = accept && (opc == OP_WRELEM);
    stb.clrMask   = accept && (opc == OP_CLRMASK);
    stb.popCnt    = accept && (opc == OP_POPCNT);
    stb.cmpStart  = accept && isCmpCmd;
    stb.stepCmp   = live && cmpQ;
    stb.stepArith = live && !cmpQ;
    stb.useScalar = scalarSelQ;
    stb.doSub     = subQ;
    stb.pred      = pred_e'(predQ);
    stb.idx       = elemIdx;
    stb.wrIdx     = cmdIdx;
    stb.dst       = busy ? dstQ : cmdDst;
    stb.srcA      = srcAQ;
    stb.srcB      = srcBQ;
    stb.scalar    = busy ? scalarQ : cmdScalar;
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> busy);
endmodule

// File: rtl/vlane_dp.sv
module vlane_dp
  import vlane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [REG_W-1:0]  rdReg,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ELEM_W-1:0] rdData,
  output logic [MAX_VL-1:0] maskBits,
  output logic              maskOn,
  output logic [VL_W-1:0]   popCount,
  output logic [VL_W-1:0]   vl
);
  logic [ELEM_W-1:0] vreg [NUM_VREG][MAX_VL];
  logic [ELEM_W-1:0] opA, opB, result;
  logic              hit, laneOn;
  logic [VL_W-1:0]   onesCnt;

  always_comb begin
    opA    = vreg[stb.srcA][stb.idx];
    opB    = stb.useScalar ? stb.scalar : vreg[stb.srcB][stb.idx];
    result = stb.doSub ? (opA - opB) : (opA + opB);
    laneOn = !maskOn || maskBits[stb.idx];
    rdData = vreg[rdReg][rdIdx];
    unique case (stb.pred)
      PR_EQ:   hit = (opA == opB);
      PR_NE:   hit = (opA != opB);
      PR_GT:   hit = ($signed(opA) >  $signed(opB));
      PR_LT:   hit = ($signed(opA) <  $signed(opB));
      PR_GE:   hit = ($signed(opA) >= $signed(opB));
      PR_LE:   hit = ($signed(opA) <= $signed(opB));
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < MAX_VL; i++) onesCnt = onesCnt + VL_W'(maskBits[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_VREG; r++)
        for (int e = 0; e < MAX_VL; e++) vreg[r][e] <= '0;
    end else if (stb.wrElem) begin
      vreg[stb.dst][stb.wrIdx] <= stb.scalar;
    end else if (stb.stepArith && laneOn) begin
      vreg[stb.dst][stb.idx] <= result;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits <= '1;
      maskOn   <= 1'b0;
      popCount <= '0;
      vl       <= VL_W'(MAX_VL);
    end else begin
      if (stb.clrMask) begin
        maskBits <= '1;
        maskOn   <= 1'b0;
      end else if (stb.cmpStart) begin
        maskBits <= '0;
        maskOn   <= 1'b1;
      end else if (stb.stepCmp) begin
        maskBits[stb.idx] <= hit;
      end
      if (stb.popCnt) popCount <= onesCnt;
      if (stb.setVl) begin
        if (stb.scalar > ELEM_W'(MAX_VL)) vl <= VL_W'(MAX_VL);
        else                              vl <= stb.scalar[VL_W-1:0];
      end
    end
  end

  // R2
  vl_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    vl <= VL_W'(MAX_VL));

  // R8
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> ((&maskBits) && !maskOn));

  // R4
  cmp_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmpStart |=> (maskOn && (maskBits == '0)));

  // R9
  pop_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.popCnt |=> (popCount == $past(onesCnt)));
endmodule

// File: rtl/vlane_top.sv
module vlane_top
  import vlane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [2:0]        cmdPred,
  input  logic [REG_W-1:0]  cmdDst,
  input  logic [REG_W-1:0]  cmdSrcA,
  input  logic [REG_W-1:0]  cmdSrcB,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [ELEM_W-1:0] cmdScalar,
  output logic              busy,
  output logic              done,
  input  logic [REG_W-1:0]  rdReg,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ELEM_W-1:0] rdData,
  output logic [MAX_VL-1:0] maskBits,
  output logic              maskOn,
  output logic [VL_W-1:0]   popCount,
  output logic [VL_W-1:0]   vlen
);
  strobe_t stb;

  vlane_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPred(cmdPred), .cmdDst(cmdDst), .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB),
    .cmdIdx(cmdIdx), .cmdScalar(cmdScalar), .vl(vlen), .stb(stb),
    .busy(busy), .done(done)
  );

  vlane_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdReg(rdReg), .rdIdx(rdIdx),
    .rdData(rdData), .maskBits(maskBits), .maskOn(maskOn),
    .popCount(popCount), .vl(vlen)
  );
endmodule

// File: tb/test_vlane_top.sv
module test_vlane_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [2:0]  cmdPred = '0;
  logic [1:0]  cmdDst = '0, cmdSrcA = '0, cmdSrcB = '0;
  logic [5:0]  cmdIdx = '0;
  logic [63:0] cmdScalar = '0;
  logic        busy, done, maskOn;
  logic [1:0]  rdReg = '0;
  logic [5:0]  rdIdx = '0;
  logic [63:0] rdData, maskBits;
  logic [6:0]  popCount, vlen;

  int nChecks = 0;
  int nFails  = 0;

  longint     mdl [4][64];
  logic [63:0] mMask = '1;
  logic        mOn = 1'b0;
  int          mVl = 64;

  typedef struct packed {
    logic [3:0]  op;
    logic [2:0]  pred;
    logic [63:0] sc;
    logic [6:0]  vl;
  } cmp_t;

  localparam cmp_t CMP_TAB [8] = '{
    '{4'd3, 3'd0, 64'd0, 7'd64},
    '{4'd3, 3'd1, 64'd0, 7'd64},
    '{4'd3, 3'd2, 64'd0, 7'd40},
    '{4'd3, 3'd3, 64'd0, 7'd64},
    '{4'd4, 3'd4, 64'hFFFF_FFFF_FFFF_FFFD, 7'd64},
    '{4'd4, 3'd5, 64'd5, 7'd33},
    '{4'd4, 3'd0, 64'hFFFF_FFFF_FFFF_FFF0, 7'd64},
    '{4'd3, 3'd2, 64'd0, 7'd48}
  };

  vlane_top i_vlane_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPred(cmdPred), .cmdDst(cmdDst), .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB),
    .cmdIdx(cmdIdx), .cmdScalar(cmdScalar), .busy(busy), .done(done),
    .rdReg(rdReg), .rdIdx(rdIdx), .rdData(rdData), .maskBits(maskBits),
    .maskOn(maskOn), .popCount(popCount), .vlen(vlen)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic predHolds(input int p, input longint a, input longint b);
    case (p)
      0: return a == b;
      1: return a != b;
      2: return a >  b;
      3: return a <  b;
      4: return a >= b;
      5: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input logic [3:0] op, input logic [2:0] pr, input logic [1:0] d,
                       input logic [1:0] a, input logic [1:0] b, input logic [5:0] ix,
                       input logic [63:0] sc);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPred = pr; cmdDst = d;
    cmdSrcA = a; cmdSrcB = b; cmdIdx = ix; cmdScalar = sc;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  task automatic setLen(input int n);
    issue(4'd1, 3'd0, 2'd0, 2'd0, 2'd0, 6'd0, 64'(n));
    mVl = (n > 64) ? 64 : n;
    chk("R2 length", 64'(vlen), 64'(mVl));
  endtask

  task automatic wrEl(input int r, input int i, input longint v);
    issue(4'd2, 3'd0, 2'(r), 2'd0, 2'd0, 6'(i), 64'(v));
    mdl[r][i] = v;
  endtask

  task automatic rdEl(input int r, input int i, output logic [63:0] v);
    @(negedge clk);
    rdReg = 2'(r); rdIdx = 6'(i);
    #1 v = rdData;
  endtask

  task automatic waitWalk(input string req);
    int cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    chk({req, " R10 busy length"}, 64'(cyc), 64'((mVl == 0) ? 1 : mVl));
    chk({req, " R10 done pulse"}, 64'(done), 64'd1);
    @(negedge clk);
    chk({req, " R10 done drop"}, 64'(done), 64'd0);
  endtask

  task automatic runCmp(input logic [3:0] op, input int pr, input int a, input int b,
                        input logic [63:0] sc);
    issue(op, 3'(pr), 2'd0, 2'(a), 2'(b), 6'd0, sc);
    for (int i = 0; i < 64; i++)
      mMask[i] = (i < mVl) && predHolds(pr, mdl[a][i],
                                        (op == 4'd4) ? longint'(sc) : mdl[b][i]);
    mOn = 1'b1;
    waitWalk("compare");
  endtask

  task automatic runArith(input logic [3:0] op, input int d, input int a, input int b,
                          input logic [63:0] sc);
    issue(op, 3'd0, 2'(d), 2'(a), 2'(b), 6'd0, sc);
    for (int i = 0; i < mVl; i++) begin
      longint ob = (op == 4'd7 || op == 4'd8) ? longint'(sc) : mdl[b][i];
      if (!mOn || mMask[i])
        mdl[d][i] = (op == 4'd6 || op == 4'd8) ? mdl[a][i] - ob : mdl[a][i] + ob;
    end
    waitWalk("arith");
  endtask

  task automatic checkReg(input string req, input int r);
    logic [63:0] v;
    for (int i = 0; i < 64; i++) begin
      rdEl(r, i, v);
      chk(req, v, 64'(mdl[r][i]));
    end
  endtask

  task automatic checkPop(input string req);
    issue(4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd0);
    chk(req, 64'(popCount), 64'($countones(mMask)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 64; i++) mdl[r][i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 vlen", 64'(vlen), 64'd64);
    chk("R1 mask", maskBits, '1);
    chk("R1 maskOn", 64'(maskOn), 64'd0);
    chk("R1 popCount", 64'(popCount), 64'd0);
    rdEl(3, 63, v);
    chk("R1 element", v, 64'd0);

    // R2 saturation
    setLen(200);
    setLen(64);

    // R3 element writes, read back
    for (int i = 0; i < 64; i++) begin
      wrEl(0, i, longint'(i) - 20);
      wrEl(1, i, 10 - longint'(i));
    end
    rdEl(0, 5, v);
    chk("R3 read v0[5]", v, 64'(-15));
    rdEl(1, 63, v);
    chk("R3 read v1[63]", v, 64'(-53));

    // R4 R5 R6 R9 table of compares
    foreach (CMP_TAB[k]) begin
      setLen(int'(CMP_TAB[k].vl));
      runCmp(CMP_TAB[k].op, int'(CMP_TAB[k].pred), 0, 1, CMP_TAB[k].sc);
      chk((CMP_TAB[k].op == 4'd4) ? "R5 R6 mask" : "R4 R6 mask", maskBits, mMask);
      chk("R4 maskOn", 64'(maskOn), 64'd1);
      checkPop("R9 popcount");
    end

    // R7 R6 masked arithmetic, length 48, mask from last compare
    runArith(4'd5, 2, 0, 1, 64'd0);
    checkReg("R7 R6 masked add", 2);
    runArith(4'd8, 3, 0, 0, 64'd7);
    checkReg("R7 masked sub scalar", 3);

    // R8 mask clear
    issue(4'd10, 3'd0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd0);
    mMask = '1; mOn = 1'b0;
    chk("R8 mask ones", maskBits, '1);
    chk("R8 maskOn low", 64'(maskOn), 64'd0);
    checkPop("R9 popcount after clear");
    setLen(64);
    runArith(4'd6, 2, 0, 1, 64'd0);
    checkReg("R8 R7 unmasked sub", 2);
    runArith(4'd7, 3, 1, 0, 64'd100);
    checkReg("R8 R7 unmasked add scalar", 3);

    // R11 commands during busy are dropped
    issue(4'd3, 3'd0, 2'd0, 2'd0, 2'd1, 6'd0, 64'd0);
    for (int i = 0; i < 64; i++) mMask[i] = (mdl[0][i] == mdl[1][i]);
    mOn = 1'b1;
    issue(4'd2, 3'd0, 2'd2, 2'd0, 2'd0, 6'd0, 64'd12345);
    issue(4'd1, 3'd0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd5);
    issue(4'd10, 3'd0, 2'd0, 2'd0, 2'd0, 6'd0, 64'd0);
    while (busy) @(negedge clk);
    rdEl(2, 0, v);
    chk("R11 element kept", v, 64'(mdl[2][0]));
    chk("R11 length kept", 64'(vlen), 64'd64);
    chk("R11 mask kept", maskBits, mMask);
    chk("R11 maskOn kept", 64'(maskOn), 64'd1);

    // R6 R10 zero length
    setLen(0);
    runCmp(4'd3, 0, 0, 0, 64'd0);
    chk("R6 zero length mask", maskBits, 64'd0);
    checkPop("R9 zero popcount");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule